// File: doc/BRIEF.md
# Composite-Field AES Forward Substitution Box

This block is the byte substitution of the AES cipher, built as pure combinational logic with no clock. One byte goes in and the substituted byte comes out. The result is the multiplicative inverse of the input in GF(2^8), followed by the standard affine transform. The block holds no lookup table. The input is carried by a linear change of basis into a tower field. That field is built from GF(2^2), extended to GF((2^2)^2), and extended again to GF(((2^2)^2)^2). The inverse is found there with small sub-field multipliers. The return to the standard basis and the affine matrix are merged into one XOR network.

The logic runs in three cascaded stages, each an AND array feeding an XOR array.

- **Stage 1** maps the byte into the tower basis. It forms the 4-bit norm `lambda*hi^2 + hi*lo + lo^2` of the two nibble halves.
- **Stage 2** inverts that norm in GF(16).
- **Stage 3** multiplies the inverted norm with the two halves and applies the merged output matrix.

The mapped byte travels beside stage 2 through a matched bypass path, so it reaches stage 3 at the same time as the inverted norm. Callers place registers around the block as they wish.

Top module: `sbox_tower`

## Requirements
- R1: For every input byte, `outWord` equals `affine(inv(inWord))`. The inverse is taken in GF(2^8) modulo x^8+x^4+x^3+x+1. The affine step sets output bit i to `a[i]^a[(i+4)%8]^a[(i+5)%8]^a[(i+6)%8]^a[(i+7)%8]`, XORed with bit i of 0x63.
- R2: Input 0x00 is treated as having inverse 0x00, so it yields 0x63.
- R3: Input 0x01 yields 0x7C, and input 0x53 yields 0xED.
- R4: The mapping is a bijection: the 256 inputs give 256 distinct outputs.
- R5: No input maps to itself, and no input maps to its bitwise complement.
- R6: The output follows a change of `inWord` within the same time step, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| inWord | input | 8 | Byte to substitute |
| outWord | output | 8 | Substituted byte |

## Verification
The bound checker watches the combinational value at every change of the input. It checks four things:

- a zero input gives 0x63;
- the output never equals the input;
- the stage-1 norm is nonzero whenever the input is nonzero;
- the stage-2 result multiplied by that norm gives one in GF(16), which shows the middle stage really inverts.

The complete function needs the bench's sweep of all 256 bytes against an arithmetic reference. That covers the exact value of each byte, the bijection over the whole byte range, the absence of complement fixed points and the same-step response.

// File: rtl/sbox_tower_pkg.sv
package sbox_tower_pkg;

  localparam int BYTE_W = 8;
  localparam int NIB_W  = 4;
  localparam int PAIR_W = 2;
  localparam int MAT_W  = BYTE_W * BYTE_W;

  localparam logic [BYTE_W-1:0] AFFINE_CONST = 8'h63;
  // z^2 + z + lambda defines the top extension; lambda = (x+1)*y
  localparam logic [NIB_W-1:0] LAMBDA = 4'b1100;

  typedef logic [MAT_W-1:0] bitMat_t;

  // GF(4) with x^2 = x + 1, element {hi, lo}
  function automatic logic [1:0] gf4Mul(input logic [1:0] a, input logic [1:0] b);
    logic [1:0] r;
    r[1] = (a[1] & b[1]) ^ (a[1] & b[0]) ^ (a[0] & b[1]);
    r[0] = (a[1] & b[1]) ^ (a[0] & b[0]);
    return r;
  endfunction

  function automatic logic [1:0] gf4Sq(input logic [1:0] a);
    return {a[1], a[1] ^ a[0]};
  endfunction

  // multiply by phi = x
  function automatic logic [1:0] gf4MulPhi(input logic [1:0] a);
    return {a[1] ^ a[0], a[1]};
  endfunction

  // GF(16) over GF(4) with y^2 = y + phi, element {hi, lo}
  function automatic logic [3:0] gf16Mul(input logic [3:0] a, input logic [3:0] b);
    logic [1:0] hh, hi, lo;
    hh = gf4Mul(a[3:2], b[3:2]);
    hi = hh ^ gf4Mul(a[3:2], b[1:0]) ^ gf4Mul(a[1:0], b[3:2]);
    lo = gf4MulPhi(hh) ^ gf4Mul(a[1:0], b[1:0]);
    return {hi, lo};
  endfunction

  function automatic logic [3:0] gf16Sq(input logic [3:0] a);
    logic [1:0] hs;
    hs = gf4Sq(a[3:2]);
    return {hs, gf4MulPhi(hs) ^ gf4Sq(a[1:0])};
  endfunction

  // GF(256) over GF(16) with z^2 = z + lambda (used to derive the basis change)
  function automatic logic [7:0] gfTowerMul(input logic [7:0] a, input logic [7:0] b);
    logic [3:0] hh, hi, lo;
    hh = gf16Mul(a[7:4], b[7:4]);
    hi = hh ^ gf16Mul(a[7:4], b[3:0]) ^ gf16Mul(a[3:0], b[7:4]);
    lo = gf16Mul(hh, LAMBDA) ^ gf16Mul(a[3:0], b[3:0]);
    return {hi, lo};
  endfunction

  // XOR of the matrix columns selected by the set bits of v
  function automatic logic [7:0] matApply(input bitMat_t m, input logic [7:0] v);
    logic [7:0] r;
    r = '0;
    for (int i = 0; i < BYTE_W; i++) begin
      r ^= m[i*BYTE_W +: BYTE_W] & {BYTE_W{v[i]}};
    end
    return r;
  endfunction

  function automatic logic [7:0] affineLinear(input logic [7:0] a);
    logic [7:0] r;
    for (int i = 0; i < BYTE_W; i++) begin
      r[i] = a[i] ^ a[(i+4)%8] ^ a[(i+5)%8] ^ a[(i+6)%8] ^ a[(i+7)%8];
    end
    return r;
  endfunction

  // first tower element g satisfying g^8+g^4+g^3+g+1 = 0
  function automatic logic [7:0] findRoot();
    logic [7:0] g, p2, p3, p4, p8;
    logic found;
    g = 8'h02;
    found = 1'b0;
    for (int c = 2; c < 256; c++) begin
      if (!found) begin
        p2 = gfTowerMul(8'(c), 8'(c));
        p3 = gfTowerMul(p2, 8'(c));
        p4 = gfTowerMul(p2, p2);
        p8 = gfTowerMul(p4, p4);
        if ((p8 ^ p4 ^ p3 ^ 8'(c) ^ 8'h01) == 8'h00) begin
          g = 8'(c);
          found = 1'b1;
        end
      end
    end
    return g;
  endfunction

  // column i = image of x^i
  function automatic bitMat_t buildIso();
    bitMat_t m;
    logic [7:0] g, pw;
    g = findRoot();
    pw = 8'h01;
    for (int i = 0; i < BYTE_W; i++) begin
      m[i*BYTE_W +: BYTE_W] = pw;
      pw = gfTowerMul(pw, g);
    end
    return m;
  endfunction

  // inverse basis change merged with the affine matrix
  function automatic bitMat_t buildOut(input bitMat_t iso);
    bitMat_t m;
    logic [7:0] v;
    m = '0;
    for (int a = 1; a < 256; a++) begin
      v = matApply(iso, 8'(a));
      for (int j = 0; j < BYTE_W; j++) begin
        if (v == (8'h01 << j)) m[j*BYTE_W +: BYTE_W] = affineLinear(8'(a));
      end
    end
    return m;
  endfunction

  localparam bitMat_t ISO_MAT = buildIso();
  localparam bitMat_t OUT_MAT = buildOut(ISO_MAT);

endpackage

// File: rtl/sbox_stage_norm.sv
module sbox_stage_norm
  import sbox_tower_pkg::*;
(
  input  logic [BYTE_W-1:0] inWord,
  output logic [BYTE_W-1:0] mappedWord,
  output logic [NIB_W-1:0]  normVal
);
  logic [NIB_W-1:0] hiPart, loPart;

  always_comb begin
    mappedWord = matApply(ISO_MAT, inWord);
    hiPart = mappedWord[BYTE_W-1:NIB_W];
    loPart = mappedWord[NIB_W-1:0];
    normVal = gf16Mul(gf16Sq(hiPart), LAMBDA) ^ gf16Mul(hiPart, loPart) ^ gf16Sq(loPart);
  end
endmodule

// File: rtl/sbox_stage_inv.sv
module sbox_stage_inv
  import sbox_tower_pkg::*;
(
  input  logic [NIB_W-1:0] normVal,
  output logic [NIB_W-1:0] normInv
);
  logic [PAIR_W-1:0] hiPart, loPart, subNorm, subInv;

  always_comb begin
    hiPart = normVal[NIB_W-1:PAIR_W];
    loPart = normVal[PAIR_W-1:0];
    subNorm = gf4MulPhi(gf4Sq(hiPart)) ^ gf4Mul(hiPart, loPart) ^ gf4Sq(loPart);
    subInv = gf4Sq(subNorm);
    normInv = {gf4Mul(hiPart, subInv), gf4Mul(hiPart ^ loPart, subInv)};
  end
endmodule

// File: rtl/sbox_bypass.sv
module sbox_bypass #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 2
) (
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);
  logic [WIDTH-1:0] chain [DEPTH+1];

  assign chain[0] = dIn;
  generate
    for (genvar k = 0; k < DEPTH; k++) begin : g_tap
      assign chain[k+1] = chain[k];
    end
  endgenerate
  assign dOut = chain[DEPTH];
endmodule

// File: rtl/sbox_stage_out.sv
module sbox_stage_out
  import sbox_tower_pkg::*;
(
  input  logic [BYTE_W-1:0] mappedWord,
  input  logic [NIB_W-1:0]  normInv,
  output logic [BYTE_W-1:0] outWord
);
  logic [NIB_W-1:0] hiPart, loPart;
  logic [BYTE_W-1:0] towerInv;

  always_comb begin
    hiPart = mappedWord[BYTE_W-1:NIB_W];
    loPart = mappedWord[NIB_W-1:0];
    towerInv = {gf16Mul(hiPart, normInv), gf16Mul(hiPart ^ loPart, normInv)};
    outWord = matApply(OUT_MAT, towerInv) ^ AFFINE_CONST;
  end
endmodule

// File: rtl/sbox_tower.sv
module sbox_tower
  import sbox_tower_pkg::*;
#(
  parameter int BYPASS_DEPTH = 2
) (
  input  logic [7:0] inWord,
  output logic [7:0] outWord
);
  logic [BYTE_W-1:0] mappedWord, mappedDly;
  logic [NIB_W-1:0]  normVal, normInv;

  sbox_stage_norm u_norm (.inWord(inWord), .mappedWord(mappedWord), .normVal(normVal));
  sbox_stage_inv  u_inv  (.normVal(normVal), .normInv(normInv));
  sbox_bypass #(.WIDTH(BYTE_W), .DEPTH(BYPASS_DEPTH)) u_byp (.dIn(mappedWord), .dOut(mappedDly));
  sbox_stage_out  u_out  (.mappedWord(mappedDly), .normInv(normInv), .outWord(outWord));
endmodule

// File: rtl/sbox_tower_chk.sv
module sbox_tower_chk
  import sbox_tower_pkg::*;
(
  input logic [7:0] inWord,
  input logic [7:0] outWord,
  input logic [3:0] normVal,
  input logic [3:0] normInv
);
  always_comb begin
    assert_zero_map_R2: assert (inWord != 8'h00 || outWord == 8'h63)
      else $error("zero input gave %h", outWord);
    assert_no_fixed_point_R5: assert (outWord != inWord)
      else $error("fixed point at %h", inWord);
    assert_norm_nonzero_R1: assert (inWord == 8'h00 || normVal != 4'h0)
      else $error("zero norm for %h", inWord);
    assert_norm_inverse_R1: assert (normVal == 4'h0 || gf16Mul(normVal, normInv) == 4'h1)
      else $error("norm %h not inverted by %h", normVal, normInv);
  end
endmodule

bind sbox_tower sbox_tower_chk u_chk (
  .inWord(inWord), .outWord(outWord), .normVal(normVal), .normInv(normInv)
);

// File: tb/sim_sbox_tower.sv
module sim_sbox_tower;
  logic clk = 1'b0;
  always #10 clk = ~clk; // 20 ns period, 50 MHz

  logic [7:0] inWord;
  logic [7:0] outWord;
  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;
  bit seen [256];

  sbox_tower u0 (.inWord(inWord), .outWord(outWord));

  function automatic logic [7:0] refMul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, x;
    p = 8'h00;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p ^= x;
      x = x[7] ? ((x << 1) ^ 8'h1B) : (x << 1);
    end
    return p;
  endfunction

  function automatic logic [7:0] refSbox(input logic [7:0] a);
    logic [7:0] inv, r, c;
    inv = 8'h00;
    for (int k = 1; k < 256; k++) begin
      if (a != 8'h00 && refMul(a, 8'(k)) == 8'h01) inv = 8'(k);
    end
    c = 8'h63;
    for (int i = 0; i < 8; i++) begin
      r[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ c[i];
    end
    return r;
  endfunction

  task automatic checkVal(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s in=%h actual=%h expected=%h", req, inWord, act, exp);
    end
  endtask

  task automatic checkTrue(input string req, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s in=%h actual=%0d expected=%0d", req, inWord, act, exp);
    end
  endtask

  initial begin
    int distinct;
    inWord = 8'h00;
    #1;
    checkVal("R2 zero byte", outWord, 8'h63);
    inWord = 8'h53;
    #1; // no clock edge between drive and sample
    checkVal("R6 same-step response", outWord, 8'hED);
    checkVal("R3 known 0x53", outWord, 8'hED);
    inWord = 8'h01;
    #1;
    checkVal("R3 known 0x01", outWord, 8'h7C);
    inWord = 8'hFF;
    #1;
    checkVal("R6 same-step response", outWord, refSbox(8'hFF));

    for (int v = 0; v < 256; v++) begin
      inWord = 8'(v);
      #5;
      checkVal("R1 full sweep", outWord, refSbox(8'(v)));
      checkTrue("R5 no fixed point", outWord != inWord, int'(outWord), -1);
      checkTrue("R5 no complement point", outWord != ~inWord, int'(outWord), -1);
      seen[outWord] = 1'b1;
    end
    distinct = 0;
    for (int k = 0; k < 256; k++) if (seen[k]) distinct++;
    checkTrue("R4 bijection", distinct == 256, distinct, 256);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule